// File: doc/BRIEF.md
# Single-Precision Compare and Sign-Manipulation Unit

This block takes single-precision floating-point operands and carries out ordered comparison or a sign-bit operation on them. It accepts a new operation on every clock and returns each result a fixed number of cycles later. A tag travels with each operation so that a surrounding pipeline can match results to requests. It handles subnormal (denormalized) operands exactly like any other finite value. No unfinished or unsupported-operand indication exists, because no input ever needs outside help.

Two compare flavours are offered. The quiet one raises the invalid flag only for signalling NaNs. The signalling one raises it for any NaN operand. The sign operations (copy, negate, absolute value) touch bit 31 at most and never raise a flag, even when the operand is a NaN.

Top module: `fcmp_sgn_unit`

## Requirements
- R1: An operation presented with `in_valid` high at a rising edge appears with `out_valid` high exactly 4 rising edges later (parameter `LAT`, default 4), carrying the same tag. Back-to-back operations on consecutive cycles are all accepted and come out in order.
- R2: For compares, `out_cc` encodes the relation of operand A to operand B: 0 equal, 1 A less than B, 2 A greater than B, 3 unordered (at least one NaN). NaN means exponent field bits 30:23 all ones with a nonzero fraction in bits 22:0.
- R3: +0 (0x00000000) and -0 (0x80000000) compare equal in either order.
- R4: Subnormal operands (exponent field zero, nonzero fraction) are ordered by their exact value, including against zeros and against each other across signs.
- R5: The quiet compare (opcode 0) sets `out_inv` only when an operand is a signalling NaN, meaning a NaN with fraction bit 22 clear. Quiet NaNs (bit 22 set) give unordered without the flag.
- R6: The signalling compare (opcode 1) sets `out_inv` whenever either operand is a NaN of any kind.
- R7: Move (opcode 2) returns operand A unchanged. Negate (opcode 3) inverts only bit 31. Absolute value (opcode 4) clears only bit 31. These operations report `out_cc` 0 and `out_inv` 0, including for NaN inputs.
- R8: Opcodes 5, 6 and 7 behave as move. Operand B is ignored by all sign operations.
- R9: A compare result reports `out_res` as zero. While `out_valid` is low, `out_cc`, `out_res`, `out_tag` and `out_inv` are all zero.
- R10: After synchronous active-high reset, `out_valid` is low and all outputs are zero until a new operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 3 | Opcode: 0 quiet compare, 1 signalling compare, 2 move, 3 negate, 4 absolute value |
| in_a | input | 32 | Operand A |
| in_b | input | 32 | Operand B (compares only) |
| in_tag | input | 4 | Identifier returned with the result |
| out_valid | output | 1 | Result strobe |
| out_cc | output | 2 | Compare condition code |
| out_res | output | 32 | Sign-operation result |
| out_tag | output | 4 | Tag of the completed operation |
| out_inv | output | 1 | Invalid-operation flag |

## Verification
The hardest cases to reach from the ports are the bit patterns near the class boundaries: a signalling NaN with only the lowest fraction bit set, a quiet NaN with nothing but bit 22 set, the largest subnormal beside the smallest normal, and signed zeros set against subnormals of the opposite sign. Random 32-bit words almost never land on these patterns. The stimulus therefore draws operands from a pool of such boundary values, mixed with random words, under all opcodes. The operations are issued back to back with occasional idle gaps, so that tag order and latency are checked while the pipeline is full.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [2:0] {
    OPC_CMP  = 3'd0,
    OPC_CMPX = 3'd1,
    OPC_MOVE = 3'd2,
    OPC_NEG  = 3'd3,
    OPC_ABS  = 3'd4
  } fcs_op_e;

  typedef enum logic [1:0] {
    CC_EQ    = 2'd0,
    CC_LT    = 2'd1,
    CC_GT    = 2'd2,
    CC_UNORD = 2'd3
  } fcs_cc_e;

  function automatic logic is_compare(input logic [2:0] op);
    return (op == OPC_CMP) || (op == OPC_CMPX);
  endfunction

endpackage

// File: rtl/fcs_classify.sv
module fcs_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] opd,
  output logic                 is_zero,
  output logic                 is_nan,
  output logic                 is_snan
);
  localparam int DW = 1 + EXP_W + MAN_W;

  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] frac;

  always_comb begin
    expo    = opd[DW-2 -: EXP_W];
    frac    = opd[MAN_W-1:0];
    is_zero = (expo == '0) && (frac == '0);
    is_nan  = (expo == '1) && (frac != '0);
    is_snan = is_nan && !frac[MAN_W-1];
  end
endmodule

// File: rtl/fcs_order.sv
module fcs_order #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] opa,
  input  logic [EXP_W+MAN_W:0] opb,
  input  logic                 zero_a,
  input  logic                 zero_b,
  input  logic                 nan_a,
  input  logic                 nan_b,
  input  logic                 snan_a,
  input  logic                 snan_b,
  input  logic                 signalling,
  output logic [1:0]           cc,
  output logic                 inv
);
  import fcs_pkg::*;
  localparam int DW = 1 + EXP_W + MAN_W;

  logic sa, sb, mag_lt, unord;

  always_comb begin
    sa     = opa[DW-1];
    sb     = opb[DW-1];
    mag_lt = opa[DW-2:0] < opb[DW-2:0];
    unord  = nan_a | nan_b;
    inv    = signalling ? unord : (snan_a | snan_b);
    if (unord)
      cc = CC_UNORD;
    else if ((zero_a && zero_b) || (opa == opb))
      cc = CC_EQ;
    else if (sa != sb)
      cc = sa ? CC_LT : CC_GT;
    else if (mag_lt ^ sa)
      cc = CC_LT;
    else
      cc = CC_GT;
  end
endmodule

// File: rtl/fcs_signop.sv
module fcs_signop #(
  parameter int DW = 32
) (
  input  logic [2:0]    op,
  input  logic [DW-1:0] opd,
  output logic [DW-1:0] res
);
  import fcs_pkg::*;

  always_comb begin
    unique case (op)
      OPC_NEG: res = {~opd[DW-1], opd[DW-2:0]};
      OPC_ABS: res = {1'b0, opd[DW-2:0]};
      default: res = opd;
    endcase
  end
endmodule

// File: rtl/fcs_delay.sv
module fcs_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_regs
      logic [W-1:0] stage [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
        end else begin
          stage[0] <= d;
          for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
        end
      end
      assign q = stage[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/fcmp_sgn_unit.sv
module fcmp_sgn_unit #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int TAG_W = 4,
  parameter int LAT   = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [2:0]             in_op,
  input  logic [EXP_W+MAN_W:0]   in_a,
  input  logic [EXP_W+MAN_W:0]   in_b,
  input  logic [TAG_W-1:0]       in_tag,
  output logic                   out_valid,
  output logic [1:0]             out_cc,
  output logic [EXP_W+MAN_W:0]   out_res,
  output logic [TAG_W-1:0]       out_tag,
  output logic                   out_inv
);
  import fcs_pkg::*;

  localparam int DW    = 1 + EXP_W + MAN_W;
  localparam int TAIL  = (LAT > 3) ? LAT - 3 : 1;
  localparam int PKT_W = 1 + 2 + DW + TAG_W + 1;

  // stage 1: captured request
  logic             s1_v;
  logic [2:0]       s1_op;
  logic [DW-1:0]    s1_opd [2];
  logic [TAG_W-1:0] s1_tag;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v      <= 1'b0;
      s1_op     <= '0;
      s1_opd[0] <= '0;
      s1_opd[1] <= '0;
      s1_tag    <= '0;
    end else begin
      s1_v      <= in_valid;
      s1_op     <= in_op;
      s1_opd[0] <= in_a;
      s1_opd[1] <= in_b;
      s1_tag    <= in_tag;
    end
  end

  // stage 2: operand classes
  logic [1:0]       c_zero, c_nan, c_snan;
  logic             s2_v;
  logic [2:0]       s2_op;
  logic [DW-1:0]    s2_opd [2];
  logic [TAG_W-1:0] s2_tag;
  logic [1:0]       s2_zero, s2_nan, s2_snan;

  generate
    for (genvar g = 0; g < 2; g++) begin : g_cls
      fcs_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
        .opd     (s1_opd[g]),
        .is_zero (c_zero[g]),
        .is_nan  (c_nan[g]),
        .is_snan (c_snan[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_v      <= 1'b0;
      s2_op     <= '0;
      s2_opd[0] <= '0;
      s2_opd[1] <= '0;
      s2_tag    <= '0;
      s2_zero   <= '0;
      s2_nan    <= '0;
      s2_snan   <= '0;
    end else begin
      s2_v      <= s1_v;
      s2_op     <= s1_op;
      s2_opd[0] <= s1_opd[0];
      s2_opd[1] <= s1_opd[1];
      s2_tag    <= s1_tag;
      s2_zero   <= c_zero;
      s2_nan    <= c_nan;
      s2_snan   <= c_snan;
    end
  end

  // stage 3: evaluate
  logic [1:0]    o_cc;
  logic          o_inv;
  logic [DW-1:0] o_res;

  fcs_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_order (
    .opa        (s2_opd[0]),
    .opb        (s2_opd[1]),
    .zero_a     (s2_zero[0]),
    .zero_b     (s2_zero[1]),
    .nan_a      (s2_nan[0]),
    .nan_b      (s2_nan[1]),
    .snan_a     (s2_snan[0]),
    .snan_b     (s2_snan[1]),
    .signalling (s2_op == OPC_CMPX),
    .cc         (o_cc),
    .inv        (o_inv)
  );

  fcs_signop #(.DW(DW)) u_sign (
    .op  (s2_op),
    .opd (s2_opd[0]),
    .res (o_res)
  );

  logic [PKT_W-1:0] s3_pkt;
  logic [PKT_W-1:0] tail_pkt;
  logic             cmp2;

  assign cmp2 = is_compare(s2_op);

  always_ff @(posedge clk) begin
    if (rst || !s2_v) begin
      s3_pkt <= '0;
    end else if (cmp2) begin
      s3_pkt <= {1'b1, o_cc, {DW{1'b0}}, s2_tag, o_inv};
    end else begin
      s3_pkt <= {1'b1, 2'b00, o_res, s2_tag, 1'b0};
    end
  end

  // stage 4..LAT: output registers
  fcs_delay #(.W(PKT_W), .DEPTH(TAIL)) u_tail (
    .clk (clk),
    .rst (rst),
    .d   (s3_pkt),
    .q   (tail_pkt)
  );

  assign {out_valid, out_cc, out_res, out_tag, out_inv} = tail_pkt;

endmodule

// File: rtl/fcs_chk.sv
module fcs_chk #(
  parameter int DW    = 32,
  parameter int TAG_W = 4,
  parameter int LAT   = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [TAG_W-1:0] in_tag,
  input logic             out_valid,
  input logic [1:0]       out_cc,
  input logic [DW-1:0]    out_res,
  input logic [TAG_W-1:0] out_tag,
  input logic             out_inv
);
  logic             sh_v [LAT];
  logic [TAG_W-1:0] sh_t [LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LAT; i++) begin
        sh_v[i] <= 1'b0;
        sh_t[i] <= '0;
      end
    end else begin
      sh_v[0] <= in_valid;
      sh_t[0] <= in_tag;
      for (int i = 1; i < LAT; i++) begin
        sh_v[i] <= sh_v[i-1];
        sh_t[i] <= sh_t[i-1];
      end
    end
  end

  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid == sh_v[LAT-1]);

  assert_tag_order_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_tag == sh_t[LAT-1]);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_cc == 2'd0 && out_res == '0 && out_tag == '0 && !out_inv));

  assert_inv_unordered_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_inv) |-> out_cc == 2'd3);

  assert_signop_noflag_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_res != '0) |-> (out_cc == 2'd0 && !out_inv));
endmodule

bind fcmp_sgn_unit fcs_chk #(.DW(DW), .TAG_W(TAG_W), .LAT(LAT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_tag    (in_tag),
  .out_valid (out_valid),
  .out_cc    (out_cc),
  .out_res   (out_res),
  .out_tag   (out_tag),
  .out_inv   (out_inv)
);

// File: tb/tb_fcmp_sgn_unit.sv
module tb_fcmp_sgn_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  in_op;
  logic [31:0] in_a, in_b;
  logic [3:0]  in_tag;
  logic        out_valid;
  logic [1:0]  out_cc;
  logic [31:0] out_res;
  logic [3:0]  out_tag;
  logic        out_inv;

  fcmp_sgn_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_tag(in_tag), .out_valid(out_valid),
    .out_cc(out_cc), .out_res(out_res), .out_tag(out_tag), .out_inv(out_inv)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [1:0]  cc;
    logic [31:0] res;
    logic        inv;
    logic [3:0]  tag;
    int          cyc;
    string       req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  int   cyc    = 0;
  logic [3:0] tag_ctr = '0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit f_nan(input logic [31:0] x);
    return x[30:23] == 8'hFF && x[22:0] != 0;
  endfunction

  function automatic logic [31:0] f_key(input logic [31:0] x);
    logic [31:0] y;
    y = (x[30:0] == 0) ? 32'h0 : x;
    return y[31] ? ~y : (y ^ 32'h8000_0000);
  endfunction

  task automatic issue(input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] b, input string req);
    exp_t e;
    @(posedge clk); #1;
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_tag = tag_ctr;
    e.tag = tag_ctr; e.cyc = cyc + 4; e.req = req;
    e.cc = 2'd0; e.res = 32'h0; e.inv = 1'b0;
    if (op <= 3'd1) begin
      if (f_nan(a) || f_nan(b)) begin
        e.cc  = 2'd3;
        e.inv = (op == 3'd1) ? 1'b1 : ((f_nan(a) && !a[22]) || (f_nan(b) && !b[22]));
      end else if (f_key(a) == f_key(b)) e.cc = 2'd0;
      else if (f_key(a) < f_key(b))      e.cc = 2'd1;
      else                               e.cc = 2'd2;
    end else if (op == 3'd3) e.res = a ^ 32'h8000_0000;
    else if (op == 3'd4)     e.res = a & 32'h7FFF_FFFF;
    else                     e.res = a;
    q.push_back(e);
    tag_ctr = tag_ctr + 1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b0; in_op = '0; in_a = '0; in_b = '0; in_tag = '0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        checks++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL R1 unexpected result tag=%0d expected none", out_tag);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (out_cc !== e.cc || out_res !== e.res || out_inv !== e.inv ||
              out_tag !== e.tag || cyc != e.cyc) begin
            fails++;
            $display("FAIL %s cc=%0d res=%h inv=%0b tag=%0d cyc=%0d expected cc=%0d res=%h inv=%0b tag=%0d cyc=%0d",
                     e.req, out_cc, out_res, out_inv, out_tag, cyc,
                     e.cc, e.res, e.inv, e.tag, e.cyc);
          end
        end
      end else if (q.size() > 0 && cyc > q[0].cyc) begin
        checks++; fails++;
        $display("FAIL R1 result tag=%0d missing at cycle %0d expected valid", q[0].tag, q[0].cyc);
        void'(q.pop_front());
      end else if (out_cc !== 2'd0 || out_res !== 32'h0 || out_inv !== 1'b0 || out_tag !== 4'h0) begin
        checks++; fails++;
        $display("FAIL R9 idle outputs cc=%0d res=%h inv=%0b tag=%0d expected all zero",
                 out_cc, out_res, out_inv, out_tag);
      end
    end
  end

  logic [31:0] pool [16];

  initial begin
    pool[0]  = 32'h0000_0000; pool[1]  = 32'h8000_0000;
    pool[2]  = 32'h0000_0001; pool[3]  = 32'h8000_0001;
    pool[4]  = 32'h007F_FFFF; pool[5]  = 32'h0080_0000;
    pool[6]  = 32'h7F80_0000; pool[7]  = 32'hFF80_0000;
    pool[8]  = 32'h7F80_0001; pool[9]  = 32'h7FC0_0000;
    pool[10] = 32'hFFBF_FFFF; pool[11] = 32'h3F80_0000;
    pool[12] = 32'hBF80_0000; pool[13] = 32'h7F7F_FFFF;
    pool[14] = 32'h807F_FFFF; pool[15] = 32'hFFC0_0001;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_op = '0; in_a = '0; in_b = '0; in_tag = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_cc !== 2'd0 || out_res !== 32'h0 || out_inv !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset outputs valid=%0b cc=%0d res=%h inv=%0b expected all zero",
               out_valid, out_cc, out_res, out_inv);
    end
    rst = 1'b0;
    idle(3);
    // R2 ordering of normals
    issue(3'd0, 32'h3F80_0000, 32'h4000_0000, "R2");
    issue(3'd0, 32'hBF80_0000, 32'hC000_0000, "R2");
    issue(3'd0, 32'h7F80_0000, 32'h7F7F_FFFF, "R2");
    issue(3'd1, 32'h4040_0000, 32'h4040_0000, "R2");
    // R3 signed zeros
    issue(3'd0, 32'h0000_0000, 32'h8000_0000, "R3");
    issue(3'd1, 32'h8000_0000, 32'h0000_0000, "R3");
    // R4 subnormals
    issue(3'd0, 32'h0000_0001, 32'h0000_0002, "R4");
    issue(3'd0, 32'h8000_0001, 32'h0000_0001, "R4");
    issue(3'd0, 32'h0000_0001, 32'h8000_0000, "R4");
    issue(3'd0, 32'h807F_FFFF, 32'h8000_0001, "R4");
    issue(3'd1, 32'h007F_FFFF, 32'h0080_0000, "R4");
    idle(2);
    // R5 quiet compare with NaNs
    issue(3'd0, 32'h7FC0_0000, 32'h3F80_0000, "R5");
    issue(3'd0, 32'h3F80_0000, 32'h7F80_0001, "R5");
    issue(3'd0, 32'hFFC0_0000, 32'hFFC0_0000, "R5");
    // R6 signalling compare
    issue(3'd1, 32'h7FC0_0000, 32'h3F80_0000, "R6");
    issue(3'd1, 32'h0000_0000, 32'hFF80_0001, "R6");
    // R7 sign operations
    issue(3'd2, 32'h7F80_0001, 32'h1234_5678, "R7");
    issue(3'd3, 32'h7F80_0001, 32'h0, "R7");
    issue(3'd3, 32'h8000_0000, 32'h0, "R7");
    issue(3'd4, 32'hFFC0_0000, 32'h0, "R7");
    issue(3'd4, 32'h8000_0001, 32'hFFFF_FFFF, "R7");
    // R8 spare opcodes and ignored B
    issue(3'd5, 32'hC0A0_0000, 32'hFFFF_FFFF, "R8");
    issue(3'd6, 32'h8000_0003, 32'h7FC0_0000, "R8");
    issue(3'd7, 32'h0123_4567, 32'h7F80_0001, "R8");
    idle(6);
    // mixed traffic from boundary pool and random words
    for (int n = 0; n < 600; n++) begin
      logic [31:0] a, b;
      logic [2:0]  op;
      a  = ($urandom_range(0, 2) == 0) ? $urandom() : pool[$urandom_range(0, 15)];
      b  = ($urandom_range(0, 2) == 0) ? $urandom() : pool[$urandom_range(0, 15)];
      if ($urandom_range(0, 3) == 0) b = a ^ 32'h8000_0000;
      op = 3'($urandom_range(0, 7));
      if (op > 3'd4) op = 3'($urandom_range(0, 1));
      issue(op, a, b, (op <= 3'd1) ? "R2" : "R7");
      if ($urandom_range(0, 9) == 0) idle($urandom_range(1, 3));
    end
    idle(10);
    if (q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R1 %0d results outstanding expected 0", q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R1 watchdog expired expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule